// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Port

This block is the register side of a battery-style real-time clock. Software reaches it through two byte ports that share one data bus. A write to the even port (`port_sel` low) picks a register index. An access on the odd port (`port_sel` high) then reads or writes the register at that index. The block holds the running time (seconds, minutes, hours), an alarm time, four plain date bytes, and four control and status registers, named A to D.

A one-second strobe from an external divider advances the time. On each such strobe the block raises the update-ended flag. It also raises the alarm flag when the new time equals the alarm time. A second divider strobe warns that an update is coming, and a third strobe marks a periodic event. The status flags are combined with the enable bits into one level interrupt request.

Software freezes the clock while it loads a new time by setting a freeze bit. The status register clears itself when it is read.

Top module: `rtc_index_port`

## Requirements
- R1: A write on the even port stores the low 7 bits of `wdata` as the index, so 0x8B selects index 0x0B. A read on the even port returns 0xFF on `rdata` in the cycle after the read strobe. Every data-port read also shows its value in the cycle after the strobe.
- R2: The register map is: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 to 9 date bytes, 10 A, 11 B, 12 C, 13 D. A data write at an index of 14 or more changes nothing, and a data read there returns 0x00.
- R3: Bit 7 of register A is the update-in-progress flag (UIP) and cannot be written. A write to A replaces bits 6:0 only. UIP is set by `upd_soon` while the freeze bit is clear, and it is cleared by `tick_1hz`.
- R4: Bit 7 of register B is the freeze bit. Writing B with bit 7 set clears UIP. While the freeze bit is set, `tick_1hz` does not move the time, and writes to the time registers land unchanged.
- R5: After the freeze bit is cleared, the next tick counts on from the time that was written.
- R6: A tick with the freeze bit clear advances the time in binary. Seconds and minutes wrap after 59 and hours wrap after 23, each wrap carrying into the next field. The same tick sets UF (bit 4 of C).
- R7: A tick with the freeze bit clear sets AF (bit 5 of C) when the new seconds, minutes and hours all equal the alarm registers. A tick while frozen sets no flag.
- R8: Enable bits in B are PIE (bit 6), AIE (bit 5) and UIE (bit 4). They pair with PF (bit 6), AF (bit 5) and UF (bit 4) in C. IRQF (bit 7 of C) is the OR of each flag ANDed with its enable, and `irq` is high whenever IRQF is set.
- R9: A data read of C returns its value and clears C to zero, which drops `irq`. A flag event in the same cycle as the read survives the clear.
- R10: Data writes to C and D are ignored, and D always reads 0x00.
- R11: A write to B that sets an enable whose flag is already pending raises `irq` in the cycle after the write.
- R12: After reset every register reads zero and `irq` is low.
- R13: A pulse on `per_evt` sets PF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe for the selected port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| upd_soon | input | 1 | Divider warning that an update is coming |
| tick_1hz | input | 1 | One-second update strobe |
| per_evt | input | 1 | Periodic event strobe |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong status flag appears on `irq` one cycle after the event or the write to B that exposes it. The same error shows in the first read of C, which also clears the flag. A wrong time counter or carry is hidden until software reads the time field. The bench therefore reads every field straight after the tick that should move it, including the full 23:59:59 rollover. A lost freeze or a bad UIP state shows on the next read of A or of the time, one cycle after that read strobe.

// File: rtl/rtc_pkg.sv
// Package: register indices, bit positions and the time record shared by
// the clock register port and its sub-blocks.
package rtc_pkg;
    localparam int IDX_W = 7;

    localparam logic [IDX_W-1:0] IX_SEC   = 7'd0;
    localparam logic [IDX_W-1:0] IX_ASEC  = 7'd1;
    localparam logic [IDX_W-1:0] IX_MIN   = 7'd2;
    localparam logic [IDX_W-1:0] IX_AMIN  = 7'd3;
    localparam logic [IDX_W-1:0] IX_HR    = 7'd4;
    localparam logic [IDX_W-1:0] IX_AHR   = 7'd5;
    localparam logic [IDX_W-1:0] IX_DATE0 = 7'd6;
    localparam int               DATE_N   = 4;
    localparam logic [IDX_W-1:0] IX_A     = 7'd10;
    localparam logic [IDX_W-1:0] IX_B     = 7'd11;
    localparam logic [IDX_W-1:0] IX_C     = 7'd12;
    localparam logic [IDX_W-1:0] IX_D     = 7'd13;
    localparam logic [IDX_W-1:0] NUM_REGS = 7'd14;

    localparam int BIT_FRZ  = 7;  // register B: freeze bit
    localparam int BIT_UIP  = 7;  // register A: update in progress
    localparam int BIT_IRQF = 7;  // register C: interrupt summary
    localparam int EN_LO    = 4;  // enables / flags occupy bits 6:4

    typedef struct packed {
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } hms_t;
endpackage

// File: rtl/rtc_time_core.sv
// Time counter: holds seconds, minutes and hours. It advances them in
// binary when adv is high and wraps each field at its limit with a carry.
// A field write takes priority over the advance for that field only.
// Assumes adv is already gated by the freeze bit.
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int SEC_MAX = 59,
    parameter int MIN_MAX = 59,
    parameter int HR_MAX  = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hr,
    input  logic [7:0] wdata,
    output hms_t       cur,
    output hms_t       nxt
);
    localparam logic [7:0] SEC_LIM = 8'(SEC_MAX);
    localparam logic [7:0] MIN_LIM = 8'(MIN_MAX);
    localparam logic [7:0] HR_LIM  = 8'(HR_MAX);

    logic sec_wrap, min_wrap, hr_wrap;

    // Next time after one second, with the carry chain.
    always_comb begin
        sec_wrap = (cur.sec >= SEC_LIM);
        min_wrap = (cur.min >= MIN_LIM);
        hr_wrap  = (cur.hr  >= HR_LIM);
        nxt.sec  = sec_wrap ? 8'd0 : cur.sec + 8'd1;
        nxt.min  = !sec_wrap ? cur.min : (min_wrap ? 8'd0 : cur.min + 8'd1);
        nxt.hr   = !(sec_wrap && min_wrap) ? cur.hr : (hr_wrap ? 8'd0 : cur.hr + 8'd1);
    end

    // Time registers: advance, then let software writes override fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else begin
            if (adv)    cur     <= nxt;
            if (wr_sec) cur.sec <= wdata;
            if (wr_min) cur.min <= wdata;
            if (wr_hr)  cur.hr  <= wdata;
        end
    end

    // R6
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !wr_sec && !wr_min && cur.sec == SEC_LIM && cur.min < MIN_LIM
        |=> cur.sec == 8'd0 && cur.min == $past(cur.min) + 8'd1);
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Alarm comparator: reports when the time about to be loaded equals the
// stored alarm time in all three fields. Purely combinational.
module rtc_alarm_cmp
    import rtc_pkg::*;
(
    input  hms_t nxt_t,
    input  hms_t alm_t,
    output logic hit
);
    // Match all three fields.
    always_comb hit = (nxt_t.sec == alm_t.sec) && (nxt_t.min == alm_t.min)
                      && (nxt_t.hr == alm_t.hr);
endmodule

// File: rtl/rtc_status.sv
// Status logic: holds the PF/AF/UF flags and the UIP bit. It clears the
// flags on a read of the status register, with new events taking priority
// over that clear, and combines the flags with the enables into IRQF.
// Flags and enables use the order {periodic, alarm, update}.
module rtc_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_soon,
    input  logic       tick,
    input  logic       frozen,
    input  logic       frz_wr,
    input  logic       rd_clr,
    input  logic [2:0] evt,
    input  logic [2:0] en,
    output logic [2:0] flags,
    output logic       irqf,
    output logic       uip
);
    // Flag register: clear on read, events set.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (rd_clr ? 3'b000 : flags) | evt;
    end

    // UIP: armed by the divider warning, dropped by the update or by freeze.
    always_ff @(posedge clk) begin
        if (!rst_n)                uip <= 1'b0;
        else if (frz_wr || tick)   uip <= 1'b0;
        else if (upd_soon && !frozen) uip <= 1'b1;
    end

    // Interrupt summary.
    always_comb irqf = |(flags & en);

    // R9
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr && evt == 3'b000 |=> flags == 3'b000);
    // R4
    frz_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frz_wr |=> !uip);
    // R13
    pf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[2] |=> flags[2]);
endmodule

// File: rtl/rtc_index_port.sv
// Clock register port: an index/data port pair in front of the time core,
// the alarm comparator and the status logic. It also holds the index,
// register A (low bits), register B, the alarm time and the date bytes.
// Read data is registered and valid in the cycle after the read strobe.
// Assumes single-cycle strobes from a bus master in this clock domain.
module rtc_index_port
    import rtc_pkg::*;
#(
    parameter int SEC_MAX = 59,
    parameter int MIN_MAX = 59,
    parameter int HR_MAX  = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       upd_soon,
    input  logic       tick_1hz,
    input  logic       per_evt,
    output logic       irq
);
    logic [IDX_W-1:0] idx_q;
    logic [6:0]       a_lo;
    logic [7:0]       reg_b;
    hms_t             alm_q, cur_t, nxt_t;
    logic [7:0]       date_rd [DATE_N];
    logic             dwr_ok, frozen, adv, hit, rd_clr, frz_wr, irqf, uip;
    logic             wr_sec, wr_min, wr_hr;
    logic [2:0]       flags;
    logic [7:0]       rd_val;

    // Strobe decode.
    always_comb begin
        dwr_ok = wr_en && port_sel && (idx_q < NUM_REGS);
        frozen = reg_b[BIT_FRZ];
        adv    = tick_1hz && !frozen;
        rd_clr = rd_en && port_sel && (idx_q == IX_C);
        frz_wr = dwr_ok && (idx_q == IX_B) && wdata[BIT_FRZ];
        wr_sec = dwr_ok && (idx_q == IX_SEC);
        wr_min = dwr_ok && (idx_q == IX_MIN);
        wr_hr  = dwr_ok && (idx_q == IX_HR);
    end

    // Index register and writable control/alarm registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            a_lo  <= '0;
            reg_b <= '0;
            alm_q <= '0;
        end else begin
            if (wr_en && !port_sel) idx_q <= wdata[IDX_W-1:0];
            if (dwr_ok) begin
                case (idx_q)
                    IX_A:    a_lo      <= wdata[6:0];
                    IX_B:    reg_b     <= wdata;
                    IX_ASEC: alm_q.sec <= wdata;
                    IX_AMIN: alm_q.min <= wdata;
                    IX_AHR:  alm_q.hr  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Date bytes: plain storage, one register per index.
    for (genvar g = 0; g < DATE_N; g++) begin : g_date
        logic [7:0] q;
        // Store one date byte.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      q <= '0;
            else if (dwr_ok && idx_q == IX_DATE0 + 7'(g))    q <= wdata;
        end
        assign date_rd[g] = q;
    end

    rtc_time_core #(.SEC_MAX(SEC_MAX), .MIN_MAX(MIN_MAX), .HR_MAX(HR_MAX)) u_time (
        .clk(clk), .rst_n(rst_n), .adv(adv), .wr_sec(wr_sec), .wr_min(wr_min),
        .wr_hr(wr_hr), .wdata(wdata), .cur(cur_t), .nxt(nxt_t)
    );

    rtc_alarm_cmp u_alarm (.nxt_t(nxt_t), .alm_t(alm_q), .hit(hit));

    rtc_status u_stat (
        .clk(clk), .rst_n(rst_n), .upd_soon(upd_soon), .tick(tick_1hz),
        .frozen(frozen), .frz_wr(frz_wr), .rd_clr(rd_clr),
        .evt({per_evt, adv && hit, adv}), .en(reg_b[EN_LO+2:EN_LO]),
        .flags(flags), .irqf(irqf), .uip(uip)
    );

    // Read multiplexer for the data port.
    always_comb begin
        rd_val = 8'h00;
        case (idx_q)
            IX_SEC:  rd_val = cur_t.sec;
            IX_MIN:  rd_val = cur_t.min;
            IX_HR:   rd_val = cur_t.hr;
            IX_ASEC: rd_val = alm_q.sec;
            IX_AMIN: rd_val = alm_q.min;
            IX_AHR:  rd_val = alm_q.hr;
            IX_A:    rd_val = {uip, a_lo};
            IX_B:    rd_val = reg_b;
            IX_C:    rd_val = {irqf, flags, 4'b0000};
            default: begin
                for (int g = 0; g < DATE_N; g++)
                    if (idx_q == IX_DATE0 + 7'(g)) rd_val = date_rd[g];
            end
        endcase
    end

    // Registered read data; the index port reads as all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= port_sel ? rd_val : 8'hFF;
    end

    assign irq = irqf;

    // R2
    oob_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && port_sel && idx_q >= NUM_REGS |=> $stable(reg_b) && $stable(alm_q));
    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !wr_sec && !wr_min && !wr_hr |=> $stable(cur_t));
    // R3
    uip_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dwr_ok && idx_q == IX_A && !tick_1hz && !upd_soon |=> uip == $past(uip));
    // R11
    en_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dwr_ok && idx_q == IX_B && wdata[EN_LO] && flags[0] && !rd_clr |=> irq);
endmodule

// File: tb/rtc_index_port_tb.sv
// Directed bench for the clock register port: one task per scenario.
module rtc_index_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       upd_soon = 1'b0, tick_1hz = 1'b0, per_evt = 1'b0;
    logic       irq;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    rtc_index_port u_dut (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .upd_soon(upd_soon),
        .tick_1hz(tick_1hz), .per_evt(per_evt), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic [7:0] d);
        @(negedge clk); port_sel = sel; wr_en = 1'b1; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic sel, output logic [7:0] d);
        @(negedge clk); port_sel = sel; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
        bus_wr(1'b0, ix); bus_wr(1'b1, d);
    endtask

    task automatic rd_reg(input logic [7:0] ix, output logic [7:0] d);
        bus_wr(1'b0, ix); bus_rd(1'b1, d);
    endtask

    task automatic do_tick;
        @(negedge clk); tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic do_upd;
        @(negedge clk); upd_soon = 1'b1; @(negedge clk); upd_soon = 1'b0;
    endtask

    task automatic do_per;
        @(negedge clk); per_evt = 1'b1; @(negedge clk); per_evt = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R12 irq", {7'b0, irq}, 8'h00);
        rd_reg(8'd11, d); check("R12 B", d, 8'h00);
        rd_reg(8'd12, d); check("R12 C", d, 8'h00);
        rd_reg(8'd0, d);  check("R12 sec", d, 8'h00);
        rd_reg(8'd10, d); check("R12 A", d, 8'h00);
    endtask

    task automatic t_index;
        logic [7:0] d;
        bus_wr(1'b0, 8'h8B); bus_wr(1'b1, 8'h0F);
        rd_reg(8'd11, d); check("R1 index low bits", d, 8'h0F);
        bus_rd(1'b0, d);  check("R1 even port read", d, 8'hFF);
        wr_reg(8'd11, 8'h00);
        wr_reg(8'd7, 8'h5C);
        rd_reg(8'd7, d);  check("R2 date byte", d, 8'h5C);
    endtask

    task automatic t_oob;
        logic [7:0] d;
        wr_reg(8'd0, 8'd7);
        bus_wr(1'b0, 8'hC0); bus_wr(1'b1, 8'hAA);
        bus_rd(1'b1, d);  check("R2 out-of-range read", d, 8'h00);
        wr_reg(8'd14, 8'h33);
        bus_rd(1'b1, d);  check("R2 index 14 read", d, 8'h00);
        rd_reg(8'd0, d);  check("R2 sec untouched", d, 8'd7);
        rd_reg(8'd11, d); check("R2 B untouched", d, 8'h00);
    endtask

    task automatic t_rega;
        logic [7:0] d;
        do_upd;
        rd_reg(8'd10, d); check("R3 UIP set", d, 8'h80);
        wr_reg(8'd10, 8'h2A);
        rd_reg(8'd10, d); check("R3 UIP kept on write", d, 8'hAA);
        do_tick;
        rd_reg(8'd10, d); check("R3 UIP cleared by tick", d, 8'h2A);
        wr_reg(8'd10, 8'hFF);
        rd_reg(8'd10, d); check("R3 UIP not writable", d, 8'h7F);
        rd_reg(8'd0, d);  check("R6 sec advanced", d, 8'd8);
        rd_reg(8'd12, d); check("R6 UF set", d, 8'h10);
    endtask

    task automatic t_set;
        logic [7:0] d;
        do_upd;
        wr_reg(8'd11, 8'h80);
        rd_reg(8'd10, d); check("R4 freeze clears UIP", d, 8'h7F);
        wr_reg(8'd0, 8'd30); wr_reg(8'd2, 8'd10);
        do_tick;
        rd_reg(8'd0, d);  check("R4 frozen sec", d, 8'd30);
        rd_reg(8'd12, d); check("R7 no flag while frozen", d, 8'h00);
        do_upd;
        rd_reg(8'd10, d); check("R3 no UIP while frozen", d, 8'h7F);
        wr_reg(8'd11, 8'h00);
        do_tick;
        rd_reg(8'd0, d);  check("R5 resume sec", d, 8'd31);
        rd_reg(8'd2, d);  check("R5 resume min", d, 8'd10);
    endtask

    task automatic t_count;
        logic [7:0] d;
        wr_reg(8'd0, 8'd59); wr_reg(8'd2, 8'd59); wr_reg(8'd4, 8'd23);
        rd_reg(8'd12, d);
        do_tick;
        rd_reg(8'd0, d);  check("R6 sec wrap", d, 8'd0);
        rd_reg(8'd2, d);  check("R6 min wrap", d, 8'd0);
        rd_reg(8'd4, d);  check("R6 hr wrap", d, 8'd0);
        rd_reg(8'd12, d); check("R7 alarm at zero", d, 8'h30);
        wr_reg(8'd0, 8'd59); wr_reg(8'd2, 8'd5); wr_reg(8'd4, 8'd3);
        do_tick;
        rd_reg(8'd2, d);  check("R6 min carry", d, 8'd6);
        rd_reg(8'd4, d);  check("R6 hr held", d, 8'd3);
        rd_reg(8'd12, d); check("R6 UF only", d, 8'h10);
    endtask

    task automatic t_alarm;
        logic [7:0] d;
        wr_reg(8'd1, 8'd45); wr_reg(8'd3, 8'd6); wr_reg(8'd5, 8'd3);
        wr_reg(8'd0, 8'd44);
        wr_reg(8'd11, 8'h20);
        check("R8 irq idle", {7'b0, irq}, 8'h00);
        do_tick;
        check("R8 alarm irq", {7'b0, irq}, 8'h01);
        rd_reg(8'd12, d); check("R9 C value", d, 8'hB0);
        check("R9 irq dropped", {7'b0, irq}, 8'h00);
        rd_reg(8'd12, d); check("R9 C cleared", d, 8'h00);
        do_tick;
        check("R8 UF masked", {7'b0, irq}, 8'h00);
        rd_reg(8'd12, d); check("R7 no match", d, 8'h10);
    endtask

    task automatic t_enable;
        logic [7:0] d;
        do_tick;
        check("R11 pending masked", {7'b0, irq}, 8'h00);
        wr_reg(8'd11, 8'h30);
        check("R11 irq on enable", {7'b0, irq}, 8'h01);
        rd_reg(8'd12, d); check("R11 C value", d, 8'h90);
    endtask

    task automatic t_cd;
        logic [7:0] d;
        do_tick;
        wr_reg(8'd12, 8'h00);
        check("R10 C write ignored irq", {7'b0, irq}, 8'h01);
        rd_reg(8'd12, d); check("R10 C write ignored", d, 8'h90);
        wr_reg(8'd13, 8'h55);
        rd_reg(8'd13, d); check("R10 D reads zero", d, 8'h00);
        wr_reg(8'd11, 8'h40);
    endtask

    task automatic t_pf;
        logic [7:0] d;
        do_per;
        check("R13 PF irq", {7'b0, irq}, 8'h01);
        rd_reg(8'd12, d); check("R13 PF in C", d, 8'hC0);
        // Read C in the same cycle as a new periodic event.
        bus_wr(1'b0, 8'd12);
        @(negedge clk); port_sel = 1'b1; rd_en = 1'b1; per_evt = 1'b1;
        @(negedge clk); rd_en = 1'b0; per_evt = 1'b0; d = rdata;
        check("R9 read before event", d, 8'h00);
        check("R9 event survives clear irq", {7'b0, irq}, 8'h01);
        rd_reg(8'd12, d); check("R9 event survives clear", d, 8'hC0);
        wr_reg(8'd11, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_index;
        t_oob;
        t_rega;
        t_set;
        t_count;
        t_alarm;
        t_enable;
        t_cd;
        t_pf;
        v = 8'h00;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule